// File: doc/BRIEF.md
# Nibble Accumulator ALU with Conditional Skip

This unit executes the data-path part of a small 4-bit controller's instruction set: bitwise logic on the accumulator, rotate through carry, accumulator complement, increment and decrement that test for wrap, equality compares, and carry-flag manipulation. A decoder outside the block presents one decoded operation per cycle with `op_valid`, together with the current accumulator, a register nibble, the memory nibble already read, a 4-bit immediate and the current carry. One clock later the block presents the new accumulator, register or memory nibble with per-destination write enables, the new carry, and a skip request.

Wrap tests and compares do not branch. They ask the sequencer to pass over the next instruction with a one-cycle `skip` pulse. The block also reports how many machine cycles the operation costs. That count includes the cycles needed to pass over the skipped instruction, whose length the sequencer supplies on `skip_len`. Fetch, decode, the program counter and the memory array live outside. The memory side is a read-data input and a write-data output with a write enable.

Top module: `nalu_core`

## Requirements
- R1: Opcodes 0/1 (AND), 2/3 (OR) and 4/5 (XOR) combine the accumulator with the immediate (even code) or the memory nibble (odd code). The result goes to the accumulator with `acc_we`=1, and the carry stays unchanged.
- R2: Opcode 6 (rotate right through carry) gives new carry = old A bit 0, new A bit 3 = old carry, and new A bit k = old A bit k+1 for k = 0..2. `acc_we`=1.
- R3: Opcode 7 writes the bitwise complement of the accumulator with `acc_we`=1, and the carry stays unchanged.
- R4: Opcode 8 increments the register (`reg_we`=1). Opcodes 9 (nibble at HL) and 10 (direct memory nibble) increment `mem_rd` into `mem_wd` with `mem_we`=1. `skip` is 1 exactly when the result is 0. The carry stays unchanged, and `mem_we` is raised by no other opcode.
- R5: Opcode 11 decrements the register (`reg_we`=1) and sets `skip` exactly when the result is F hex. The carry stays unchanged.
- R6: Opcodes 12 (register vs immediate), 13 (memory vs immediate), 14 (A vs memory) and 15 (A vs register) write nothing and set `skip` exactly on equality.
- R7: Opcode 16 sets the carry, 17 clears it and 18 complements it, each without a skip. Opcode 19 leaves the carry unchanged and sets `skip` equal to the carry.
- R8: `cycles` = base + (`skip` ? `skip_len` : 0). The base is 2 for opcodes 0, 2, 4, 7, 9, 10, 12, 13 and 15, and 1 for every other opcode.
- R9: All results appear in the cycle after the `op_valid` cycle, with `res_valid`=1. The enables and `skip` are 0 whenever `res_valid` is 0.
- R10: Opcodes 20 to 31 write nothing, do not skip, keep the carry and report 1 cycle.
- R11: After reset, `res_valid`, all write enables, `skip`, `cy_out` and `cycles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Decoded operation code |
| acc_in | input | 4 | Current accumulator |
| reg_in | input | 4 | Register operand |
| mem_rd | input | 4 | Memory nibble read data |
| imm | input | 4 | Immediate operand |
| cy_in | input | 1 | Current carry flag |
| skip_len | input | 2 | Machine cycles of the following instruction |
| res_valid | output | 1 | Results valid this cycle |
| acc_out | output | 4 | New accumulator |
| acc_we | output | 1 | Accumulator write enable |
| reg_out | output | 4 | New register value |
| reg_we | output | 1 | Register write enable |
| mem_wd | output | 4 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| cy_out | output | 1 | New carry flag |
| skip | output | 1 | Pass over the next instruction |
| cycles | output | 4 | Machine cycles spent, skip included |

## Verification
A wrong wrap or compare decision shows in the result cycle as a wrong `skip` and, with it, a `cycles` value off by exactly `skip_len`. Wrap values F→0 and 0→F are driven for that reason. A stale or misrouted carry shows on `cy_out` in the same cycle, and the rotate and carry opcodes are chained so that an error carries into the next check. A destination decode error shows at once as an enable raised on the wrong port, or as one still high in the cycle after the result.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

  typedef enum logic [4:0] {
    OP_AND_I  = 5'd0,
    OP_AND_M  = 5'd1,
    OP_OR_I   = 5'd2,
    OP_OR_M   = 5'd3,
    OP_XOR_I  = 5'd4,
    OP_XOR_M  = 5'd5,
    OP_RORC   = 5'd6,
    OP_NOTA   = 5'd7,
    OP_INC_R  = 5'd8,
    OP_INC_HL = 5'd9,
    OP_INC_D  = 5'd10,
    OP_DEC_R  = 5'd11,
    OP_CMP_RI = 5'd12,
    OP_CMP_MI = 5'd13,
    OP_CMP_AM = 5'd14,
    OP_CMP_AR = 5'd15,
    OP_SETC   = 5'd16,
    OP_CLRC   = 5'd17,
    OP_CPLC   = 5'd18,
    OP_TSTC   = 5'd19
  } op_e;

  // base machine cycles before any skip cost
  function automatic logic [1:0] f_base_cycles(input logic [4:0] code);
    case (code)
      5'd0, 5'd2, 5'd4, 5'd7, 5'd9, 5'd10, 5'd12, 5'd13, 5'd15: f_base_cycles = 2'd2;
      default: f_base_cycles = 2'd1;
    endcase
  endfunction

  function automatic logic f_is_acc_op(input logic [4:0] code);
    f_is_acc_op = (code <= 5'd7);
  endfunction

  function automatic logic f_is_mem_step(input logic [4:0] code);
    f_is_mem_step = (code == 5'd9) || (code == 5'd10);
  endfunction

  function automatic logic f_is_cmp(input logic [4:0] code);
    f_is_cmp = (code >= 5'd12) && (code <= 5'd15);
  endfunction

endpackage

// File: rtl/nalu_logic_unit.sv
module nalu_logic_unit
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [4:0]   code,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  input  logic [W-1:0] imm,
  input  logic         cy,
  output logic [W-1:0] res,
  output logic         cy_n
);
  logic [W-1:0] opnd;

  // odd codes in the logic group take the memory nibble
  assign opnd = code[0] ? mem : imm;

  always_comb begin
    res  = acc;
    cy_n = cy;
    case (code)
      OP_AND_I, OP_AND_M: res = acc & opnd;
      OP_OR_I,  OP_OR_M:  res = acc | opnd;
      OP_XOR_I, OP_XOR_M: res = acc ^ opnd;
      OP_RORC: begin
        res  = {cy, acc[W-1:1]};
        cy_n = acc[0];
      end
      OP_NOTA: res = ~acc;
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/nalu_step_unit.sv
module nalu_step_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] opnd,
  input  logic         down,
  output logic [W-1:0] res,
  output logic         wrap
);
  logic [W:0] ext;

  // wrap is the carry or borrow out of the extended adder
  always_comb begin
    if (down) ext = {1'b0, opnd} - {{W{1'b0}}, 1'b1};
    else      ext = {1'b0, opnd} + {{W{1'b0}}, 1'b1};
  end

  assign res  = ext[W-1:0];
  assign wrap = ext[W];
endmodule

// File: rtl/nalu_cmp_unit.sv
module nalu_cmp_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         eq
);
  logic [W-1:0] bit_eq;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign bit_eq[g] = ~(lhs[g] ^ rhs[g]);
  end

  assign eq = &bit_eq;
endmodule

// File: rtl/nalu_cycle_unit.sv
module nalu_cycle_unit
  import nalu_pkg::*;
#(
  parameter int CYC_W  = 4,
  parameter int SLEN_W = 2
) (
  input  logic [4:0]        code,
  input  logic              skip,
  input  logic [SLEN_W-1:0] slen,
  output logic [CYC_W-1:0]  cycles
);
  logic [CYC_W-1:0] base_ext;
  logic [CYC_W-1:0] extra;

  assign base_ext = CYC_W'(f_base_cycles(code));
  assign extra    = skip ? CYC_W'(slen) : '0;
  assign cycles   = base_ext + extra;
endmodule

// File: rtl/nalu_core.sv
module nalu_core
  import nalu_pkg::*;
#(
  parameter int W      = 4,
  parameter int CYC_W  = 4,
  parameter int SLEN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [W-1:0]      acc_in,
  input  logic [W-1:0]      reg_in,
  input  logic [W-1:0]      mem_rd,
  input  logic [W-1:0]      imm,
  input  logic              cy_in,
  input  logic [SLEN_W-1:0] skip_len,
  output logic              res_valid,
  output logic [W-1:0]      acc_out,
  output logic              acc_we,
  output logic [W-1:0]      reg_out,
  output logic              reg_we,
  output logic [W-1:0]      mem_wd,
  output logic              mem_we,
  output logic              cy_out,
  output logic              skip,
  output logic [CYC_W-1:0]  cycles
);
  // named internal events, observed by the checker
  logic [W-1:0]     logic_res;
  logic             logic_cy;
  logic [W-1:0]     step_in;
  logic [W-1:0]     step_res;
  logic             step_down;
  logic             step_wrap;
  logic [W-1:0]     cmp_lhs;
  logic [W-1:0]     cmp_rhs;
  logic             cmp_eq;
  logic [CYC_W-1:0] cyc_n;

  logic [W-1:0] acc_n, reg_n, mem_n;
  logic         acc_we_n, reg_we_n, mem_we_n, cy_n, skip_n;

  nalu_logic_unit #(.W(W)) i_logic (
    .code (op_code),
    .acc  (acc_in),
    .mem  (mem_rd),
    .imm  (imm),
    .cy   (cy_in),
    .res  (logic_res),
    .cy_n (logic_cy)
  );

  assign step_down = (op_code == OP_DEC_R);
  assign step_in   = f_is_mem_step(op_code) ? mem_rd : reg_in;

  nalu_step_unit #(.W(W)) i_step (
    .opnd (step_in),
    .down (step_down),
    .res  (step_res),
    .wrap (step_wrap)
  );

  always_comb begin
    case (op_code)
      OP_CMP_RI: begin cmp_lhs = reg_in; cmp_rhs = imm;    end
      OP_CMP_MI: begin cmp_lhs = mem_rd; cmp_rhs = imm;    end
      OP_CMP_AM: begin cmp_lhs = acc_in; cmp_rhs = mem_rd; end
      default:   begin cmp_lhs = acc_in; cmp_rhs = reg_in; end
    endcase
  end

  nalu_cmp_unit #(.W(W)) i_cmp (
    .lhs (cmp_lhs),
    .rhs (cmp_rhs),
    .eq  (cmp_eq)
  );

  always_comb begin
    acc_n    = acc_in;
    reg_n    = reg_in;
    mem_n    = mem_rd;
    cy_n     = cy_in;
    acc_we_n = 1'b0;
    reg_we_n = 1'b0;
    mem_we_n = 1'b0;
    skip_n   = 1'b0;
    if (f_is_acc_op(op_code)) begin
      acc_n    = logic_res;
      cy_n     = logic_cy;
      acc_we_n = 1'b1;
    end else if (f_is_cmp(op_code)) begin
      skip_n = cmp_eq;
    end else begin
      case (op_code)
        OP_INC_R, OP_DEC_R: begin
          reg_n    = step_res;
          reg_we_n = 1'b1;
          skip_n   = step_wrap;
        end
        OP_INC_HL, OP_INC_D: begin
          mem_n    = step_res;
          mem_we_n = 1'b1;
          skip_n   = step_wrap;
        end
        OP_SETC: cy_n   = 1'b1;
        OP_CLRC: cy_n   = 1'b0;
        OP_CPLC: cy_n   = ~cy_in;
        OP_TSTC: skip_n = cy_in;
        default: ;
      endcase
    end
  end

  nalu_cycle_unit #(.CYC_W(CYC_W), .SLEN_W(SLEN_W)) i_cyc (
    .code   (op_code),
    .skip   (skip_n),
    .slen   (skip_len),
    .cycles (cyc_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      acc_out   <= '0;
      reg_out   <= '0;
      mem_wd    <= '0;
      acc_we    <= 1'b0;
      reg_we    <= 1'b0;
      mem_we    <= 1'b0;
      cy_out    <= 1'b0;
      skip      <= 1'b0;
      cycles    <= '0;
    end else begin
      res_valid <= op_valid;
      acc_we    <= op_valid & acc_we_n;
      reg_we    <= op_valid & reg_we_n;
      mem_we    <= op_valid & mem_we_n;
      skip      <= op_valid & skip_n;
      if (op_valid) begin
        acc_out <= acc_n;
        reg_out <= reg_n;
        mem_wd  <= mem_n;
        cy_out  <= cy_n;
        cycles  <= cyc_n;
      end
    end
  end
endmodule

// File: rtl/nalu_core_chk.sv
module nalu_core_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [4:0]   op_code,
  input logic         cy_in,
  input logic         res_valid,
  input logic [W-1:0] reg_out,
  input logic         acc_we,
  input logic         reg_we,
  input logic         mem_we,
  input logic         cy_out,
  input logic         skip,
  input logic         step_wrap,
  input logic         cmp_eq
);
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(acc_we || reg_we || mem_we || skip));

  p_mem_we_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 5'd9 || op_code == 5'd10)) |=> mem_we);

  p_mem_we_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 5'd9 && op_code != 5'd10) |=> !mem_we);

  p_wrap_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 5'd8 && op_code <= 5'd11) |=> (skip == $past(step_wrap)));

  p_dec_f_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd11) |=> (skip == (reg_out == {W{1'b1}})));

  p_cmp_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 5'd12 && op_code <= 5'd15) |=>
      (skip == $past(cmp_eq) && !acc_we && !reg_we));

  p_logic_cy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 5'd5) |=> (cy_out == $past(cy_in)));

  p_test_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd19) |=> (skip == $past(cy_in)));

  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 5'd20) |=> !(acc_we || reg_we || mem_we || skip));
endmodule

bind nalu_core nalu_core_chk #(.W(W)) i_nalu_core_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .cy_in     (cy_in),
  .res_valid (res_valid),
  .reg_out   (reg_out),
  .acc_we    (acc_we),
  .reg_we    (reg_we),
  .mem_we    (mem_we),
  .cy_out    (cy_out),
  .skip      (skip),
  .step_wrap (step_wrap),
  .cmp_eq    (cmp_eq)
);

// File: tb/test_nalu_core.sv
`timescale 1ns/1ps
module test_nalu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [3:0] acc_in = '0, reg_in = '0, mem_rd = '0, imm = '0;
  logic       cy_in = 1'b0;
  logic [1:0] skip_len = '0;
  logic       res_valid, acc_we, reg_we, mem_we, cy_out, skip;
  logic [3:0] acc_out, reg_out, mem_wd, cycles;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  nalu_core i_nalu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .reg_in(reg_in), .mem_rd(mem_rd), .imm(imm),
    .cy_in(cy_in), .skip_len(skip_len), .res_valid(res_valid),
    .acc_out(acc_out), .acc_we(acc_we), .reg_out(reg_out), .reg_we(reg_we),
    .mem_wd(mem_wd), .mem_we(mem_we), .cy_out(cy_out), .skip(skip),
    .cycles(cycles)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int base_of(input int c);
    if (c == 0 || c == 2 || c == 4 || c == 7 || c == 9 || c == 10 ||
        c == 12 || c == 13 || c == 15) return 2;
    return 1;
  endfunction

  // drive one operation, sample its result in the following cycle
  task automatic run(input int c, input int a, input int r, input int m,
                     input int i, input int cy, input int sl);
    @(negedge clk);
    op_valid = 1'b1; op_code = 5'(c); acc_in = 4'(a); reg_in = 4'(r);
    mem_rd = 4'(m); imm = 4'(i); cy_in = cy[0]; skip_len = 2'(sl);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 res_valid", res_valid, 0);
    chk("R11 enables", {acc_we, reg_we, mem_we}, 0);
    chk("R11 skip", skip, 0);
    chk("R11 cy_out", cy_out, 0);
    chk("R11 cycles", cycles, 0);
  endtask

  task automatic t_logic;
    run(0, 4'hC, 0, 4'h3, 4'hA, 1, 1);
    chk("R1 and imm", acc_out, 4'h8);
    chk("R1 acc_we", acc_we, 1);
    chk("R1 carry kept", cy_out, 1);
    chk("R8 and imm cycles", cycles, base_of(0));
    run(3, 4'h5, 0, 4'h8, 4'h0, 0, 1);
    chk("R1 or mem", acc_out, 4'hD);
    chk("R1 carry kept", cy_out, 0);
    chk("R8 or mem cycles", cycles, base_of(3));
    run(4, 4'hF, 0, 4'h0, 4'h6, 1, 1);
    chk("R1 xor imm", acc_out, 4'h9);
    run(5, 4'h6, 0, 4'h3, 4'hF, 0, 1);
    chk("R1 xor mem", acc_out, 4'h5);
  endtask

  task automatic t_rorc;
    run(6, 4'b1011, 0, 0, 0, 0, 1);
    chk("R2 rorc acc", acc_out, 4'b0101);
    chk("R2 rorc carry", cy_out, 1);
    run(6, 4'b0110, 0, 0, 0, 1, 1);
    chk("R2 rorc acc cy-in", acc_out, 4'b1011);
    chk("R2 rorc carry", cy_out, 0);
  endtask

  task automatic t_not;
    run(7, 4'h3, 0, 0, 0, 1, 1);
    chk("R3 not", acc_out, 4'hC);
    chk("R3 carry kept", cy_out, 1);
    chk("R8 not cycles", cycles, 2);
  endtask

  task automatic t_incs;
    run(8, 0, 4'h7, 0, 0, 1, 2);
    chk("R4 inc reg", reg_out, 4'h8);
    chk("R4 no skip", skip, 0);
    chk("R4 reg_we", {reg_we, mem_we, acc_we}, 3'b100);
    chk("R4 carry kept", cy_out, 1);
    run(8, 0, 4'hF, 0, 0, 0, 2);
    chk("R4 inc reg wrap", reg_out, 0);
    chk("R4 skip on zero", skip, 1);
    chk("R8 inc skip cycles", cycles, 1 + 2);
    run(9, 0, 0, 4'hF, 0, 0, 3);
    chk("R4 inc hl wrap", mem_wd, 0);
    chk("R4 mem_we", {reg_we, mem_we, acc_we}, 3'b010);
    chk("R4 hl skip", skip, 1);
    chk("R8 hl skip cycles", cycles, 2 + 3);
    run(10, 0, 0, 4'h4, 0, 1, 3);
    chk("R4 inc direct", mem_wd, 4'h5);
    chk("R4 direct mem_we", mem_we, 1);
    chk("R4 direct no skip", skip, 0);
    chk("R8 direct cycles", cycles, 2);
  endtask

  task automatic t_decs;
    run(11, 0, 4'h0, 0, 0, 1, 1);
    chk("R5 dec wrap", reg_out, 4'hF);
    chk("R5 skip on F", skip, 1);
    chk("R5 carry kept", cy_out, 1);
    chk("R8 dec skip cycles", cycles, 2);
    run(11, 0, 4'h1, 0, 0, 0, 1);
    chk("R5 dec to zero", reg_out, 0);
    chk("R5 no skip", skip, 0);
    chk("R5 mem_we low", mem_we, 0);
  endtask

  task automatic t_cmp;
    run(12, 0, 4'h9, 0, 4'h9, 0, 2);
    chk("R6 reg=imm skip", skip, 1);
    chk("R6 no writes", {acc_we, reg_we, mem_we}, 0);
    chk("R8 cmp ri cycles", cycles, 2 + 2);
    run(13, 0, 0, 4'h2, 4'h3, 0, 2);
    chk("R6 mem!=imm", skip, 0);
    run(14, 4'hA, 0, 4'hA, 0, 0, 1);
    chk("R6 a=mem skip", skip, 1);
    chk("R8 cmp am cycles", cycles, 1 + 1);
    run(15, 4'h6, 4'h7, 0, 0, 0, 3);
    chk("R6 a!=reg", skip, 0);
    chk("R8 cmp ar cycles", cycles, 2);
    run(15, 4'h6, 4'h6, 0, 0, 0, 3);
    chk("R6 a=reg skip", skip, 1);
  endtask

  task automatic t_carry;
    run(16, 0, 0, 0, 0, 0, 1);
    chk("R7 set", cy_out, 1);
    chk("R7 set no skip", skip, 0);
    run(17, 0, 0, 0, 0, 1, 1);
    chk("R7 clear", cy_out, 0);
    run(18, 0, 0, 0, 0, 0, 1);
    chk("R7 complement", cy_out, 1);
    run(18, 0, 0, 0, 0, 1, 1);
    chk("R7 complement back", cy_out, 0);
    run(19, 0, 0, 0, 0, 1, 2);
    chk("R7 test skip", skip, 1);
    chk("R7 test carry kept", cy_out, 1);
    chk("R8 test cycles", cycles, 1 + 2);
    run(19, 0, 0, 0, 0, 0, 2);
    chk("R7 test no skip", skip, 0);
  endtask

  task automatic t_unused;
    run(23, 4'h5, 4'h6, 4'h7, 4'h8, 1, 3);
    chk("R10 no writes", {acc_we, reg_we, mem_we}, 0);
    chk("R10 no skip", skip, 0);
    chk("R10 carry kept", cy_out, 1);
    chk("R10 cycles", cycles, 1);
    run(31, 0, 0, 0, 0, 0, 3);
    chk("R10 top code", {acc_we, reg_we, mem_we, skip}, 0);
  endtask

  task automatic t_pulse;
    run(9, 0, 0, 4'hF, 0, 0, 1);
    chk("R9 valid in result cycle", res_valid, 1);
    chk("R9 skip high", skip, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 valid drops", res_valid, 0);
    chk("R9 pulse ends", {skip, mem_we}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_logic();
    t_rorc();
    t_not();
    t_incs();
    t_decs();
    t_cmp();
    t_carry();
    t_unused();
    t_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule